// File: doc/BRIEF.md
# Timestamped Link Error Event Logger

This block sits next to a bit-error checker on a serial link receiver. It turns what happens on the link into typed records: bit errors in individual words, the checker locking to the pattern, losing the link, and its own decisions to stop and restart error logging when storage runs short. Each record carries a free-running cycle timestamp, so a host can rebuild when errors occurred and how long an outage lasted.

Records are held in two internal queues. A small reserved queue takes only link-loss records, so these are kept even when the main queue is saturated with error records. The main queue takes every other event. When the main queue is close to full, error logging halts and a marker record is written. When a quarter of the main queue is free again, a second marker is written and logging restarts. The read side is show-ahead: the head record is always visible, the reserved queue is drained first, and each read strobe removes one record.

Top module: `link_event_logger`

## Requirements
- R1: A record is 91 bits: event code in bits [90:88], timestamp in bits [87:40], data in bits [39:0]. Codes: 1 bit error, 2 lock gained, 3 link lost, 4 logging halted, 5 logging resumed.
- R2: A word strobe while lock is high, no loss flag is high and logging is active, with received word different from expected word, writes a code-1 record whose data is received XOR expected. Matching words, words with the strobe low, or words while lock is low write nothing.
- R3: A rising edge of the lock input writes a code-2 record into the main queue carrying the expected word.
- R4: A rising edge of (signal-loss OR clock-loss) writes a code-3 record carrying the expected word into the reserved queue, which receives no other code, including while error logging is halted.
- R5: While either loss flag is high, no bit-error record is written.
- R6: The timestamp counts clock cycles from reset; the difference between two record timestamps equals the number of cycles between the events.
- R7: When logging is active and the main queue has two or fewer free slots, bit-error records stop, a code-4 record is written and logging halts; the main queue never overflows.
- R8: While halted, once at least a quarter of the main queue is free, a code-5 record is written and bit-error logging restarts.
- R9: Only one main-queue record is written per cycle, by priority lock gained, then halt/resume marker, then bit error; the lower candidates that cycle are dropped. A link-lost record is written in the same cycle as any of these.
- R10: The output shows the reserved queue's head whenever it holds a record, otherwise the main queue's head; rec_vld is high when either queue holds a record and each cycle with rd_en high removes that head.
- R11: After reset both queues are empty, rec_vld is low and logging is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | Checker presents a compared word this cycle |
| rx_word | input | 40 | Received word |
| exp_word | input | 40 | Expected word from the checker |
| lock_in | input | 1 | Checker locked to the pattern |
| sig_loss | input | 1 | Receiver signal loss |
| clk_loss | input | 1 | Receiver clock recovery loss |
| rd_en | input | 1 | Remove the presented record |
| rec_vld | output | 1 | A record is presented |
| rec_out | output | 91 | Presented record |

## Verification
The assertions watch on every cycle that the main queue is never written when full, that no bit-error record appears while a loss flag is high or logging is halted, that the halt and resume markers flip the logging state, that the reserved queue only takes link-lost records and gets one at each loss edge, that it wins the read side, and that the timestamp steps by one. The directed scenarios show what a single cycle cannot: the exact record sequence and data fields, timestamp differences across an outage, the dropping of a lower-priority event, and the count of error records that fit before the halt marker and the resume marker that follows draining.

// File: rtl/lel_pkg.sv
package lel_pkg;
  localparam int DATA_W = 40;
  localparam int TS_W   = 48;
  localparam int ID_W   = 3;
  localparam int REC_W  = ID_W + TS_W + DATA_W;
  localparam int STOP_FREE = 2;

  typedef enum logic [ID_W-1:0] {
    EV_NONE  = 3'd0,
    EV_ERR   = 3'd1,
    EV_LOCK  = 3'd2,
    EV_LOST  = 3'd3,
    EV_FULL  = 3'd4,
    EV_READY = 3'd5
  } ev_id_e;

  typedef struct packed {
    ev_id_e              id;
    logic [TS_W-1:0]     ts;
    logic [DATA_W-1:0]   data;
  } rec_t;

  function automatic int free_slots(int depth, int used);
    return depth - used;
  endfunction

  function automatic bit halt_due(int free);
    return free <= STOP_FREE;
  endfunction

  function automatic bit resume_due(int free, int depth);
    return free >= depth / 4;
  endfunction

  function automatic rec_t make_rec(ev_id_e id, logic [TS_W-1:0] ts,
                                    logic [DATA_W-1:0] data);
    rec_t r;
    r.id   = id;
    r.ts   = ts;
    r.data = data;
    return r;
  endfunction
endpackage

// File: rtl/lel_timestamp.sv
module lel_timestamp #(
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end
endmodule

// File: rtl/lel_fifo.sv
module lel_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 91,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  din,
  input  logic          rd_en,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lel_event_arb.sv
module lel_event_arb
  import lel_pkg::*;
#(
  parameter int MAIN_DEPTH = 16,
  localparam int CW = $clog2(MAIN_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] rx_word,
  input  logic [DATA_W-1:0] exp_word,
  input  logic              lock_in,
  input  logic              sig_loss,
  input  logic              clk_loss,
  input  logic [TS_W-1:0]   ts,
  input  logic [CW-1:0]     main_count,
  input  logic              rsv_full,
  output logic              main_wr,
  output rec_t              main_rec,
  output logic              rsv_wr,
  output rec_t              rsv_rec,
  output logic              recording
);
  logic              lost_q, lock_q, rec_q, rec_d;
  logic              lost_any, lost_evt, lock_evt;
  logic              err_cand, halt_cand, resume_cand;
  logic [DATA_W-1:0] diff;
  int                free;

  assign lost_any = sig_loss || clk_loss;
  assign lost_evt = lost_any && !lost_q;
  assign lock_evt = lock_in && !lock_q;
  assign diff     = rx_word ^ exp_word;
  assign free     = free_slots(MAIN_DEPTH, int'(main_count));

  assign err_cand    = word_vld && lock_in && !lost_any && (diff != '0) &&
                       rec_q && !halt_due(free);
  assign halt_cand   = rec_q && halt_due(free) && (free >= 1);
  assign resume_cand = !rec_q && resume_due(free, MAIN_DEPTH);

  assign rsv_wr  = lost_evt && !rsv_full;
  assign rsv_rec = make_rec(EV_LOST, ts, exp_word);

  always_comb begin
    main_wr  = 1'b0;
    main_rec = make_rec(EV_NONE, ts, exp_word);
    rec_d    = rec_q;
    if (lock_evt && free >= 1) begin
      main_wr  = 1'b1;
      main_rec = make_rec(EV_LOCK, ts, exp_word);
    end else if (halt_cand) begin
      main_wr  = 1'b1;
      main_rec = make_rec(EV_FULL, ts, exp_word);
      rec_d    = 1'b0;
    end else if (resume_cand) begin
      main_wr  = 1'b1;
      main_rec = make_rec(EV_READY, ts, exp_word);
      rec_d    = 1'b1;
    end else if (err_cand) begin
      main_wr  = 1'b1;
      main_rec = make_rec(EV_ERR, ts, diff);
    end
    if (rec_q && free == 0) rec_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= 1'b0;
      lock_q <= 1'b0;
      rec_q  <= 1'b1;
    end else begin
      lost_q <= lost_any;
      lock_q <= lock_in;
      rec_q  <= rec_d;
    end
  end

  assign recording = rec_q;
endmodule

// File: rtl/link_event_logger.sv
module link_event_logger
  import lel_pkg::*;
#(
  parameter int MAIN_DEPTH = 16,
  parameter int RSV_DEPTH  = 4,
  localparam int MCW = $clog2(MAIN_DEPTH + 1),
  localparam int RCW = $clog2(RSV_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] rx_word,
  input  logic [DATA_W-1:0] exp_word,
  input  logic              lock_in,
  input  logic              sig_loss,
  input  logic              clk_loss,
  input  logic              rd_en,
  output logic              rec_vld,
  output logic [REC_W-1:0]  rec_out
);
  logic [TS_W-1:0]  ts_now;
  logic             main_wr, rsv_wr, recording;
  rec_t             main_rec, rsv_rec;
  logic [REC_W-1:0] main_dout, rsv_dout;
  logic [MCW-1:0]   main_cnt;
  logic [RCW-1:0]   rsv_cnt;
  logic             main_empty, main_full, rsv_empty, rsv_full;
  logic             main_rd, rsv_rd;
  logic [ID_W-1:0]  main_wr_id, rsv_wr_id;

  assign main_wr_id = main_rec.id;
  assign rsv_wr_id  = rsv_rec.id;

  lel_timestamp #(.TS_W(TS_W)) ts_i (
    .clk(clk), .rst_n(rst_n), .ts(ts_now)
  );

  lel_event_arb #(.MAIN_DEPTH(MAIN_DEPTH)) arb_i (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .rx_word(rx_word),
    .exp_word(exp_word), .lock_in(lock_in), .sig_loss(sig_loss),
    .clk_loss(clk_loss), .ts(ts_now), .main_count(main_cnt),
    .rsv_full(rsv_full), .main_wr(main_wr), .main_rec(main_rec),
    .rsv_wr(rsv_wr), .rsv_rec(rsv_rec), .recording(recording)
  );

  lel_fifo #(.DEPTH(MAIN_DEPTH), .W(REC_W)) main_q_i (
    .clk(clk), .rst_n(rst_n), .wr_en(main_wr), .din(main_rec),
    .rd_en(main_rd), .dout(main_dout), .count(main_cnt),
    .empty(main_empty), .full(main_full)
  );

  lel_fifo #(.DEPTH(RSV_DEPTH), .W(REC_W)) rsv_q_i (
    .clk(clk), .rst_n(rst_n), .wr_en(rsv_wr), .din(rsv_rec),
    .rd_en(rsv_rd), .dout(rsv_dout), .count(rsv_cnt),
    .empty(rsv_empty), .full(rsv_full)
  );

  assign rsv_rd  = rd_en && !rsv_empty;
  assign main_rd = rd_en && rsv_empty && !main_empty;
  assign rec_vld = !rsv_empty || !main_empty;
  assign rec_out = !rsv_empty ? rsv_dout : main_dout;
endmodule

// File: rtl/lel_checker.sv
module lel_checker #(
  parameter int MAIN_DEPTH = 16,
  parameter int MCW = 5,
  parameter int TS_W = 48,
  parameter int REC_W = 91
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sig_loss,
  input logic             clk_loss,
  input logic             main_wr,
  input logic [2:0]       main_wr_id,
  input logic [MCW-1:0]   main_cnt,
  input logic             rsv_wr,
  input logic [2:0]       rsv_wr_id,
  input logic             rsv_full,
  input logic             rsv_empty,
  input logic             recording,
  input logic             rec_vld,
  input logic [REC_W-1:0] rec_out,
  input logic [TS_W-1:0]  ts_now
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    main_wr |-> (main_cnt < MCW'(MAIN_DEPTH))); // R7
  AST_ERR_QUIET_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    ((sig_loss || clk_loss) && main_wr) |-> (main_wr_id != 3'd1)); // R5
  AST_ERR_NEEDS_LOGGING: assert property (@(posedge clk) disable iff (!rst_n)
    (main_wr && main_wr_id == 3'd1) |-> recording); // R7
  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (main_wr && main_wr_id == 3'd4) |=> !recording); // R7
  AST_RESUME_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (main_wr && main_wr_id == 3'd5) |=> recording); // R8
  AST_LOSS_EDGE_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ((sig_loss || clk_loss) && !$past(sig_loss || clk_loss) && !rsv_full) |-> rsv_wr); // R4
  AST_RSV_ONLY_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_wr |-> (rsv_wr_id == 3'd3)); // R4
  AST_RSV_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !rsv_empty |-> (rec_vld && rec_out[REC_W-1 -: 3] == 3'd3)); // R10
  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ts_now == $past(ts_now) + 1'b1)); // R6
endmodule

bind link_event_logger lel_checker #(
  .MAIN_DEPTH(MAIN_DEPTH), .MCW(MCW), .TS_W(lel_pkg::TS_W), .REC_W(lel_pkg::REC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sig_loss(sig_loss), .clk_loss(clk_loss),
  .main_wr(main_wr), .main_wr_id(main_wr_id), .main_cnt(main_cnt),
  .rsv_wr(rsv_wr), .rsv_wr_id(rsv_wr_id), .rsv_full(rsv_full),
  .rsv_empty(rsv_empty), .recording(recording), .rec_vld(rec_vld),
  .rec_out(rec_out), .ts_now(ts_now)
);

// File: tb/link_event_logger_tb_top.sv
module link_event_logger_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_vld, lock_in, sig_loss, clk_loss, rd_en;
  logic [39:0] rx_word, exp_word;
  logic        rec_vld;
  logic [90:0] rec_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [2:0]  got_id [40];
  logic [39:0] got_data [40];
  logic [47:0] got_ts [40];
  int          got_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_event_logger dut_i (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .rx_word(rx_word),
    .exp_word(exp_word), .lock_in(lock_in), .sig_loss(sig_loss),
    .clk_loss(clk_loss), .rd_en(rd_en), .rec_vld(rec_vld), .rec_out(rec_out)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // pop every presented record, one per cycle
  task automatic drain();
    got_n = 0;
    while (rec_vld && got_n < 40) begin
      got_id[got_n]   = rec_out[90:88];
      got_ts[got_n]   = rec_out[87:40];
      got_data[got_n] = rec_out[39:0];
      got_n++;
      rd_en = 1'b1;
      step();
      rd_en = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(rec_vld == 1'b0, "R11 empty after reset", 64'(rec_vld), 0);
  endtask

  task automatic t_lock_and_errors();
    exp_word = 40'h12_3456_789A;
    rx_word  = exp_word;
    lock_in  = 1'b1;
    step();
    drain();
    chk(got_n == 1, "R3 one lock record", 64'(got_n), 1);
    chk(got_id[0] == 3'd2, "R3 lock code", 64'(got_id[0]), 2);
    chk(got_data[0] == 40'h12_3456_789A, "R1 lock data is expected word",
        64'(got_data[0]), 64'h12_3456_789A);
    word_vld = 1'b1;
    repeat (5) step();
    chk(rec_vld == 1'b0, "R2 matching words log nothing", 64'(rec_vld), 0);
    rx_word = exp_word ^ 40'h1;
    step();
    rx_word = exp_word;
    step();
    step();
    rx_word = exp_word ^ 40'h300;
    step();
    rx_word = exp_word;
    word_vld = 1'b0;
    rx_word = exp_word ^ 40'hF0;
    step();
    rx_word = exp_word;
    drain();
    chk(got_n == 2, "R2 two error records, strobe-low word ignored", 64'(got_n), 2);
    chk(got_id[0] == 3'd1 && got_id[1] == 3'd1, "R2 error code",
        64'({got_id[0], got_id[1]}), 64'h9);
    chk(got_data[0] == 40'h1, "R2 data is xor", 64'(got_data[0]), 1);
    chk(got_data[1] == 40'h300, "R2 data is xor", 64'(got_data[1]), 64'h300);
    chk(got_ts[1] - got_ts[0] == 48'd3, "R6 stamp spacing",
        64'(got_ts[1] - got_ts[0]), 3);
  endtask

  task automatic t_outage();
    sig_loss = 1'b1;
    word_vld = 1'b1;
    rx_word  = exp_word ^ 40'h8;
    step();
    repeat (3) step();
    lock_in = 1'b0;
    step();
    word_vld = 1'b0;
    rx_word  = exp_word;
    sig_loss = 1'b0;
    lock_in  = 1'b1;
    step();
    drain();
    chk(got_n == 2, "R5 no error records during loss", 64'(got_n), 2);
    chk(got_id[0] == 3'd3, "R4 lost code", 64'(got_id[0]), 3);
    chk(got_id[1] == 3'd2, "R3 relock code", 64'(got_id[1]), 2);
    chk(got_ts[1] - got_ts[0] == 48'd5, "R6 outage length",
        64'(got_ts[1] - got_ts[0]), 5);
    clk_loss = 1'b1;
    step();
    clk_loss = 1'b0;
    step();
    drain();
    chk(got_n == 1 && got_id[0] == 3'd3, "R4 clock loss logged",
        64'(got_id[0]), 3);
  endtask

  task automatic t_priority();
    lock_in = 1'b0;
    step();
    lock_in  = 1'b1;
    word_vld = 1'b1;
    rx_word  = exp_word ^ 40'h4;
    step();
    word_vld = 1'b0;
    rx_word  = exp_word;
    step();
    drain();
    chk(got_n == 1 && got_id[0] == 3'd2, "R9 lock beats error",
        64'(got_n), 1);
    lock_in = 1'b0;
    step();
    lock_in  = 1'b1;
    sig_loss = 1'b1;
    step();
    sig_loss = 1'b0;
    step();
    drain();
    chk(got_n == 2, "R9 lost and lock same cycle", 64'(got_n), 2);
    chk(got_id[0] == 3'd3 && got_id[1] == 3'd2, "R10 reserved read first",
        64'({got_id[0], got_id[1]}), 64'h1A);
    chk(got_ts[0] == got_ts[1], "R9 same stamp", 64'(got_ts[1]), 64'(got_ts[0]));
  endtask

  task automatic t_fill();
    int errs;
    word_vld = 1'b1;
    rx_word  = exp_word ^ 40'h2;
    repeat (20) step();
    word_vld = 1'b0;
    rx_word  = exp_word;
    sig_loss = 1'b1;
    step();
    sig_loss = 1'b0;
    step();
    drain();
    chk(got_n == 17, "R7 record total after fill", 64'(got_n), 17);
    chk(got_id[0] == 3'd3, "R4 R10 lost kept and read first while full",
        64'(got_id[0]), 3);
    errs = 0;
    for (int i = 1; i < 15; i++) if (got_id[i] == 3'd1) errs++;
    chk(errs == 14, "R7 errors before halt", 64'(errs), 14);
    chk(got_id[15] == 3'd4, "R7 halt marker", 64'(got_id[15]), 4);
    chk(got_id[16] == 3'd5, "R8 resume marker", 64'(got_id[16]), 5);
    word_vld = 1'b1;
    rx_word  = exp_word ^ 40'h10;
    step();
    word_vld = 1'b0;
    rx_word  = exp_word;
    step();
    drain();
    chk(got_n == 1 && got_id[0] == 3'd1 && got_data[0] == 40'h10,
        "R8 logging restarted", 64'(got_data[0]), 64'h10);
  endtask

  initial begin
    rst_n = 1'b0; word_vld = 1'b0; lock_in = 1'b0; sig_loss = 1'b0;
    clk_loss = 1'b0; rd_en = 1'b0; rx_word = '0; exp_word = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_lock_and_errors();
    t_outage();
    t_priority();
    t_fill();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule